// File: doc/BRIEF.md
# Prioritized Bus Ownership Arbiter with Hold Withdrawal

This block picks which master drives the system bus. Five requesters compete: an urgent refresh request, the DMA engine, an external master asking for the bus, the CPU, and a background refresh request. The decision is registered. An owner is replaced only at a cycle boundary: either the bus sequencer reports it is not busy, or it is in the last clock of a transfer. A change of owner always passes through at least one clock in which nobody holds the bus.

When the external master wins, the block raises the hold acknowledge output. The same level tells the bus sequencer to float its address, address/data and control drivers, and to pull the address strobe low. The external request comes from another clock domain, so it is synchronized before arbitration. If DMA or urgent refresh needs the bus during a hold, the arbiter withdraws the acknowledge. It then waits for the external master to drop its request before it hands the bus to the on-chip requester.

Top module: `bus_hold_arbiter`

## Requirements
- R1: Fixed priority from highest to lowest: urgent refresh, DMA, external hold, CPU, background refresh. The grant bits are: grant[0] urgent refresh, grant[1] DMA, grant[2] external hold, grant[3] CPU, grant[4] background refresh.
- R2: At most one grant bit is high in any cycle.
- R3: While an owner is granted, the grant stays unchanged in every cycle where seq_busy is high and seq_last is low. A boundary is seq_busy low or seq_last high.
- R4: Whenever ownership passes from one master to another, there is at least one clock with an all-zero grant in between.
- R5: hold_req goes through a two-flop synchronizer. From an idle bus, hold_ack rises at the third rising clock edge after hold_req goes high.
- R6: hold_ack equals grant[2]. float_bus is high exactly when hold_ack is high.
- R7: strobe_low is high exactly when hold_ack is high, so the sequencer drives the address strobe low rather than floating it.
- R8: During a hold, a DMA or urgent refresh request seen at a boundary drops hold_ack at the next edge, and nothing is granted in its place.
- R9: After a withdrawal, the grant stays zero until the synchronized hold request is low. The arbiter then spends one idle clock and then grants the highest pending requester.
- R10: CPU and background refresh requests never interrupt an acknowledged hold.
- R11: After reset, grant is zero and hold_ack, float_bus and strobe_low are low.
- R12: An owner keeps the bus while it is still the highest request. With no request pending, the grant returns to zero through a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| rfh_req | input | 1 | Urgent refresh request |
| dma_req | input | 1 | DMA engine request |
| hold_req | input | 1 | External master hold request, asynchronous, active high |
| cpu_req | input | 1 | CPU bus request |
| rfl_req | input | 1 | Background refresh request |
| seq_busy | input | 1 | Bus sequencer is inside a transfer |
| seq_last | input | 1 | Bus sequencer is in the final clock of a transfer |
| grant | output | 5 | One-hot registered owner, bit order as in R1 |
| hold_ack | output | 1 | Hold acknowledge to the external master |
| float_bus | output | 1 | Sequencer must float its three-state outputs |
| strobe_low | output | 1 | Sequencer must drive the address strobe low |

## Verification
The hardest state to reach is a withdrawn hold: the external master has been refused, but its request is still high behind the synchronizer, and an on-chip requester is waiting. The bench first brings the external master onto the bus. It then raises a DMA request (and, in a later pass, an urgent refresh request) and keeps hold_req high for several clocks, checking that the grant stays empty. Only then does it drop hold_req. The expected reclaim is counted through both synchronizer stages and the idle clock.

// File: rtl/bha_pkg.sv
package bha_pkg;
  localparam int NREQ    = 5;
  localparam int IDX_RFH = 0;
  localparam int IDX_DMA = 1;
  localparam int IDX_EXT = 2;
  localparam int IDX_CPU = 3;
  localparam int IDX_RFL = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OWN  = 2'd1,
    ST_WAIT = 2'd2
  } arb_state_e;
endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bha_prio.sv
module bha_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win_oh,
  output logic         win_any
);
  logic [N-1:0] above;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pick
      if (i == 0) begin : g_top
        assign above[0] = 1'b0;
      end else begin : g_rest
        assign above[i] = above[i-1] | req[i-1];
      end
      assign win_oh[i] = req[i] & ~above[i];
    end
  endgenerate

  assign win_any = |req;
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
  import bha_pkg::*;
#(
  parameter int N      = NREQ,
  parameter int EXT_IX = IDX_EXT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] win_oh,
  input  logic         win_any,
  input  logic         boundary,
  input  logic         ext_sync,
  output logic [N-1:0] grant
);
  arb_state_e   state_q, state_n;
  logic [N-1:0] grant_q, grant_n;
  logic         load_en;

  always_comb begin
    state_n = state_q;
    grant_n = grant_q;
    case (state_q)
      ST_IDLE: begin
        if (win_any) begin
          state_n = ST_OWN;
          grant_n = win_oh;
        end
      end
      ST_OWN: begin
        if (boundary && (win_oh != grant_q)) begin
          grant_n = '0;
          if (grant_q[EXT_IX] && ext_sync) state_n = ST_WAIT;
          else                             state_n = ST_IDLE;
        end
      end
      ST_WAIT: begin
        grant_n = '0;
        if (!ext_sync) state_n = ST_IDLE;
      end
      default: begin
        state_n = ST_IDLE;
        grant_n = '0;
      end
    endcase
  end

  assign load_en = (state_n != state_q) || (grant_n != grant_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grant_q <= '0;
    end else if (load_en) begin
      state_q <= state_n;
      grant_q <= grant_n;
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rfh_req,
  input  logic            dma_req,
  input  logic            hold_req,
  input  logic            cpu_req,
  input  logic            rfl_req,
  input  logic            seq_busy,
  input  logic            seq_last,
  output logic [NREQ-1:0] grant,
  output logic            hold_ack,
  output logic            float_bus,
  output logic            strobe_low
);
  logic            hold_s;
  logic [NREQ-1:0] req_vec;
  logic [NREQ-1:0] win_oh;
  logic            win_any;
  logic            boundary;

  bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hold_req),
    .q     (hold_s)
  );

  always_comb begin
    req_vec          = '0;
    req_vec[IDX_RFH] = rfh_req;
    req_vec[IDX_DMA] = dma_req;
    req_vec[IDX_EXT] = hold_s;
    req_vec[IDX_CPU] = cpu_req;
    req_vec[IDX_RFL] = rfl_req;
  end

  bha_prio #(.N(NREQ)) u_prio (
    .req     (req_vec),
    .win_oh  (win_oh),
    .win_any (win_any)
  );

  assign boundary = !seq_busy || seq_last;

  bha_fsm #(.N(NREQ), .EXT_IX(IDX_EXT)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_oh   (win_oh),
    .win_any  (win_any),
    .boundary (boundary),
    .ext_sync (hold_s),
    .grant    (grant)
  );

  assign hold_ack   = grant[IDX_EXT];
  assign float_bus  = hold_ack;
  assign strobe_low = hold_ack;
endmodule

// File: rtl/bha_checker.sv
module bha_checker #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] grant,
  input logic         hold_ack,
  input logic         float_bus,
  input logic         strobe_low,
  input logic         seq_busy,
  input logic         seq_last,
  input logic         hold_req,
  input logic         hold_s,
  input logic         rfh_req,
  input logic         dma_req
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !seq_last && (grant != '0)) |=> $stable(grant)); // R3

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((grant == $past(grant)) || (grant == '0))); // R4

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(hold_req, 2)); // R5

  AST_FLOAT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    float_bus == hold_ack); // R6

  AST_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low == float_bus); // R7

  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && (!seq_busy || seq_last) && (rfh_req || dma_req)) |=> (grant == '0)); // R8

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && hold_s && !rfh_req && !dma_req) |=> hold_ack); // R10
endmodule

bind bus_hold_arbiter bha_checker #(.N(bha_pkg::NREQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grant      (grant),
  .hold_ack   (hold_ack),
  .float_bus  (float_bus),
  .strobe_low (strobe_low),
  .seq_busy   (seq_busy),
  .seq_last   (seq_last),
  .hold_req   (hold_req),
  .hold_s     (hold_s),
  .rfh_req    (rfh_req),
  .dma_req    (dma_req)
);

// File: tb/bus_hold_arbiter_tb.sv
module bus_hold_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] G_NONE = 5'b00000;
  localparam logic [4:0] G_RFH  = 5'b00001;
  localparam logic [4:0] G_DMA  = 5'b00010;
  localparam logic [4:0] G_EXT  = 5'b00100;
  localparam logic [4:0] G_CPU  = 5'b01000;
  localparam logic [4:0] G_RFL  = 5'b10000;

  logic       clk;
  logic       rst_n;
  logic       rfh_req, dma_req, hold_req, cpu_req, rfl_req;
  logic       seq_busy, seq_last;
  logic [4:0] grant;
  logic       hold_ack, float_bus, strobe_low;

  typedef struct {
    logic [4:0] g;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks;
  int   errors;
  bit   done;

  bus_hold_arbiter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rfh_req    (rfh_req),
    .dma_req    (dma_req),
    .hold_req   (hold_req),
    .cpu_req    (cpu_req),
    .rfl_req    (rfl_req),
    .seq_busy   (seq_busy),
    .seq_last   (seq_last),
    .grant      (grant),
    .hold_ack   (hold_ack),
    .float_bus  (float_bus),
    .strobe_low (strobe_low)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_at(input int n, input logic [4:0] g, input string tag);
    exp_t it;
    repeat (n) @(negedge clk);
    it.g   = g;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic report(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: compares the expected owner and the hold outputs derived from it
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t it;
      logic h;
      it = exp_q.pop_front();
      h  = it.g[2];
      report(it.tag, grant, it.g);
      report({"R2 one owner / ", it.tag}, 5'($countones(grant) <= 1), 5'd1);
      report({"R6 hold_ack / ", it.tag}, {4'b0, hold_ack}, {4'b0, h});
      report({"R6 float_bus / ", it.tag}, {4'b0, float_bus}, {4'b0, h});
      report({"R7 strobe_low / ", it.tag}, {4'b0, strobe_low}, {4'b0, h});
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    rfh_req = 0; dma_req = 0; hold_req = 0; cpu_req = 0; rfl_req = 0;
    seq_busy = 0; seq_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_at(1, G_NONE, "R11 reset state");

    cpu_req = 1;
    expect_at(1, G_CPU, "R12 cpu granted from idle");

    seq_busy = 1; seq_last = 0; dma_req = 1;
    expect_at(2, G_CPU, "R3 no change mid transfer");
    seq_last = 1;
    expect_at(1, G_NONE, "R4 idle clock before dma");
    seq_last = 0;
    expect_at(1, G_DMA, "R1 dma over cpu");
    seq_busy = 0;

    dma_req = 0; cpu_req = 0;
    expect_at(2, G_NONE, "R12 release with no request");

    hold_req = 1;
    expect_at(2, G_NONE, "R5 hold not yet through synchronizer");
    expect_at(1, G_EXT, "R5 hold acknowledged on third edge");

    cpu_req = 1; rfl_req = 1;
    expect_at(3, G_EXT, "R10 lower requests ignored during hold");

    dma_req = 1;
    expect_at(1, G_NONE, "R8 dma withdraws hold");
    expect_at(3, G_NONE, "R9 no reclaim while hold high");
    hold_req = 0;
    expect_at(3, G_NONE, "R9 waits for synchronized release");
    expect_at(1, G_DMA, "R9 reclaim to dma");

    dma_req = 0;
    expect_at(1, G_NONE, "R4 gap dma to cpu");
    expect_at(1, G_CPU, "R1 cpu over background refresh");

    cpu_req = 0;
    expect_at(1, G_NONE, "R4 gap cpu to background refresh");
    expect_at(1, G_RFL, "R1 background refresh alone");

    rfh_req = 1; dma_req = 1; cpu_req = 1; hold_req = 1;
    expect_at(2, G_RFH, "R1 urgent refresh over all");
    rfh_req = 0; dma_req = 0; cpu_req = 0; rfl_req = 0;
    expect_at(2, G_EXT, "R1 hold after urgent refresh");

    rfh_req = 1;
    expect_at(1, G_NONE, "R8 urgent refresh withdraws hold");
    hold_req = 0;
    expect_at(3, G_NONE, "R9 refresh waits for release");
    expect_at(1, G_RFH, "R9 reclaim to urgent refresh");
    rfh_req = 0;
    expect_at(2, G_NONE, "R12 idle after refresh");

    hold_req = 1;
    expect_at(3, G_EXT, "R5 second hold");
    hold_req = 0; cpu_req = 1;
    expect_at(3, G_NONE, "R4 gap after normal hold release");
    expect_at(1, G_CPU, "R6 bus back to cpu");
    cpu_req = 0;

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule